// File: doc/BRIEF.md
# PWM Event Timer

This block is a general-purpose timer with a small synchronous register port. A 32-bit up-counter runs while a start bit is set. It can be slowed by a power-of-two prescaler. It can reload from a load register on overflow or stop there, and it can compare its value against a match register. Overflow and match events set sticky status flags, which are masked into a single interrupt line. The same events can also drive an output pin, either as a toggle or as a one-clock pulse, around a programmable idle level.

Software writes to control, counter, load, match and trigger through a posted path. Each such write lands in the timer a fixed two clocks later. A write-pending register shows which of these writes are still in flight. Back-to-back writes to the same register all land, in order. A write of the key value to the interface-control register starts a soft reset. A done bit in the system-status register reports when that reset has finished.

The read port is combinational: `bus_rdata` reflects `bus_addr` in the same cycle. Word addresses: 0 control, 1 counter, 2 load, 3 match, 4 trigger, 5 status, 6 interrupt enable, 7 write pending, 8 interface control, 9 system status.

Top module: `pwm_event_timer`

## Requirements
- R1: After hardware reset, control, counter, load, match, status, enable and write-pending all read 0. System status (address 9) bit 0 reads 1. `irq` and `pwm_out` are 0.
- R2: With control bit 0 (run) set and control bit 5 (prescale enable) clear, the counter rises by one every clock. With run clear, the counter holds its value.
- R3: With control bit 5 set, the 3-bit ratio N in control bits [4:2] makes the counter advance once every 2^(N+1) clocks of running time.
- R4: With control bit 1 (auto-reload) set, a tick at 0xFFFFFFFF loads the counter from the load register. The same tick sets status bit 0 (overflow), and run stays set.
- R5: With auto-reload clear, a tick at 0xFFFFFFFF sets the counter to 0, sets status bit 0 and clears run. The counter then stays at 0.
- R6: Any value written to the trigger register (address 4) copies the load register into the counter when the write lands.
- R7: With control bit 6 (compare enable) set, the tick that moves the counter onto the match value sets status bit 1. With compare enable clear, no match flag is raised.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it. `irq` is high when any status bit is set together with the same bit of the enable register (address 6).
- R9: A write to control, counter, load, match or trigger takes effect two clocks after the write edge. Write-pending (address 7) bit k, where k is the register's word address, reads 1 for those two cycles. A second write in the next cycle also lands, one cycle after the first.
- R10: Control bits [11:10] select the pin trigger: 0 none, 1 overflow, 2 or 3 overflow or match. Bit 7 sets the idle level. Bit 8 set toggles the pin on each event; bit 8 clear drives the inverse of the idle level for one clock per event.
- R11: Writing 0x06 to interface control (address 8) clears all timer state and write-pending entries. System status bit 0 reads 0 for the 4 cycles after that write edge and 1 afterwards. Other values written there have no effect.
- R12: The counter register can be preset by a write and read at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Masked interrupt |
| pwm_out | output | 1 | Timer output pin |

## Verification
Writes to interrupt enable, status and interface control act at the write edge. Their effects are sampled at the falling edge just after it. Posted writes land at the second edge after the write edge. A counter started at edge k therefore takes its first tick at edge k+3, and after edge k+2+m it holds m ticks (m divided by the prescale period, rounded down). Overflow and match flags, and pin changes, appear after the edge of the tick that causes them. The bench steps falling edges one at a time and reads at exactly those points.

// File: rtl/pet_pkg.sv
package pet_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 4;
    localparam int RATIO_W    = 3;
    localparam int PRE_W      = 2 ** RATIO_W;
    localparam int POST_DEPTH = 2;
    localparam int RST_CYCLES = 4;
    localparam int NPOST      = 5;
    localparam int STAT_W     = 2;
    localparam logic [DATA_W-1:0] IFC_RESET_KEY = 32'h0000_0006;

    localparam int IX_CTRL  = 0;
    localparam int IX_COUNT = 1;
    localparam int IX_LOAD  = 2;
    localparam int IX_MATCH = 3;
    localparam int IX_TRIG  = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 4'd0,
        REG_COUNT = 4'd1,
        REG_LOAD  = 4'd2,
        REG_MATCH = 4'd3,
        REG_TRIG  = 4'd4,
        REG_STAT  = 4'd5,
        REG_IEN   = 4'd6,
        REG_WPEND = 4'd7,
        REG_IFCTL = 4'd8,
        REG_SYSST = 4'd9
    } reg_idx_e;

    typedef enum logic [1:0] {
        TRIG_NONE     = 2'd0,
        TRIG_OVF      = 2'd1,
        TRIG_BOTH     = 2'd2,
        TRIG_BOTH_ALT = 2'd3
    } trig_e;

    // control word; ratio and trigger fields keep fixed positions
    typedef struct packed {
        logic [19:0]        rsv_hi;
        trig_e              trig;
        logic               rsv9;
        logic               toggle;
        logic               dflt;
        logic               cmp_en;
        logic               pre_en;
        logic [RATIO_W-1:0] ratio;
        logic               autold;
        logic               run;
    } ctrl_t;

    function automatic logic [PRE_W-1:0] pre_limit(input logic [RATIO_W-1:0] r);
        logic [PRE_W:0] span;
        span = (PRE_W+1)'(1) << (int'(r) + 1);
        return PRE_W'(span - 1'b1);
    endfunction

    function automatic ctrl_t ctrl_clean(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c        = ctrl_t'(w);
        c.rsv_hi = '0;
        c.rsv9   = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/pet_post_line.sv
module pet_post_line #(
    parameter int W     = 32,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_v,
    input  logic [W-1:0] in_d,
    output logic         out_v,
    output logic [W-1:0] out_d,
    output logic         pending
);
    logic [DEPTH-1:0] vld;
    logic [W-1:0]     dat [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else begin
            vld[0] <= in_v;
            for (int i = 1; i < DEPTH; i++) begin
                vld[i] <= vld[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        dat[0] <= in_d;
        for (int i = 1; i < DEPTH; i++) begin
            dat[i] <= dat[i-1];
        end
    end

    assign out_v   = vld[DEPTH-1];
    assign out_d   = dat[DEPTH-1];
    assign pending = |vld;
endmodule

// File: rtl/pet_prescale.sv
module pet_prescale import pet_pkg::*; (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               pre_en,
    input  logic [RATIO_W-1:0] ratio,
    output logic               tick
);
    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] lim;
    logic             wrap;

    assign lim  = pre_limit(ratio);
    assign wrap = pcnt >= lim;
    assign tick = run && (!pre_en || wrap);

    always_ff @(posedge clk) begin
        if (rst || !run || !pre_en) begin
            pcnt <= '0;
        end else if (wrap) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/pet_count_core.sv
module pet_count_core import pet_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              autold,
    input  logic              cmp_en,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] match_val,
    input  logic              cnt_wr,
    input  logic [DATA_W-1:0] cnt_wdata,
    input  logic              trig_wr,
    output logic [DATA_W-1:0] count,
    output logic              ovf_evt,
    output logic              mat_evt,
    output logic              stop_req
);
    localparam logic [DATA_W-1:0] CNT_MAX = '1;

    logic [DATA_W-1:0] nxt;
    logic              stepping;

    always_comb begin
        nxt      = count;
        ovf_evt  = 1'b0;
        stepping = 1'b0;
        if (cnt_wr) begin
            nxt = cnt_wdata;
        end else if (trig_wr) begin
            nxt = load_val;
        end else if (tick) begin
            stepping = 1'b1;
            if (count == CNT_MAX) begin
                ovf_evt = 1'b1;
                nxt     = autold ? load_val : '0;
            end else begin
                nxt = count + 1'b1;
            end
        end
    end

    assign mat_evt  = cmp_en && stepping && (nxt == match_val);
    assign stop_req = ovf_evt && !autold;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            count <= nxt;
        end
    end
endmodule

// File: rtl/pet_pin_gen.sv
module pet_pin_gen import pet_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  ovf_evt,
    input  logic  mat_evt,
    input  trig_e trig,
    input  logic  dflt,
    input  logic  toggle,
    output logic  pin
);
    logic state;
    logic fire;

    always_comb begin
        case (trig)
            TRIG_OVF:                fire = ovf_evt;
            TRIG_BOTH, TRIG_BOTH_ALT: fire = ovf_evt || mat_evt;
            default:                 fire = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || trig == TRIG_NONE) begin
            state <= 1'b0;
        end else if (toggle) begin
            if (fire) begin
                state <= ~state;
            end
        end else begin
            state <= fire;
        end
    end

    assign pin = dflt ^ state;
endmodule

// File: rtl/pwm_event_timer.sv
module pwm_event_timer import pet_pkg::*; #(
    parameter int POST_LAT = POST_DEPTH,
    parameter int SRST_LEN = RST_CYCLES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              pwm_out
);
    localparam int SRST_W = $clog2(SRST_LEN + 1);

    logic [SRST_W-1:0] srst_cnt;
    logic              busy;
    logic              core_rst;
    logic              sys_done;

    assign busy     = srst_cnt != '0;
    assign core_rst = rst | busy;
    assign sys_done = !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            srst_cnt <= '0;
        end else if (busy) begin
            srst_cnt <= srst_cnt - 1'b1;
        end else if (bus_we && bus_addr == REG_IFCTL && bus_wdata == IFC_RESET_KEY) begin
            srst_cnt <= SRST_W'(SRST_LEN);
        end
    end

    // posted write path, one delay line per posted register
    logic [NPOST-1:0] land_v;
    logic [NPOST-1:0] wpend;
    logic [DATA_W-1:0] land_d [NPOST];

    for (genvar p = 0; p < NPOST; p++) begin : g_post
        pet_post_line #(
            .W     (DATA_W),
            .DEPTH (POST_LAT)
        ) u_line (
            .clk     (clk),
            .rst     (core_rst),
            .in_v    (bus_we && !busy && bus_addr == ADDR_W'(p)),
            .in_d    (bus_wdata),
            .out_v   (land_v[p]),
            .out_d   (land_d[p]),
            .pending (wpend[p])
        );
    end

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] match_q;
    logic [DATA_W-1:0] count;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] ien_q;
    logic              tick;
    logic              ovf_evt;
    logic              mat_evt;
    logic              stop_req;
    logic              stat_wr;
    logic              ien_wr;

    assign stat_wr = bus_we && !busy && bus_addr == REG_STAT;
    assign ien_wr  = bus_we && !busy && bus_addr == REG_IEN;

    always_ff @(posedge clk) begin
        if (core_rst) begin
            ctrl_q <= '0;
        end else if (land_v[IX_CTRL]) begin
            ctrl_q <= ctrl_clean(land_d[IX_CTRL]);
        end else if (stop_req) begin
            ctrl_q.run <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (core_rst) begin
            load_q  <= '0;
            match_q <= '0;
        end else begin
            if (land_v[IX_LOAD]) begin
                load_q <= land_d[IX_LOAD];
            end
            if (land_v[IX_MATCH]) begin
                match_q <= land_d[IX_MATCH];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (core_rst) begin
            stat_q <= '0;
            ien_q  <= '0;
        end else begin
            stat_q <= (stat_q & ~(stat_wr ? bus_wdata[STAT_W-1:0] : '0)) | {mat_evt, ovf_evt};
            if (ien_wr) begin
                ien_q <= bus_wdata[STAT_W-1:0];
            end
        end
    end

    pet_prescale u_pre (
        .clk    (clk),
        .rst    (core_rst),
        .run    (ctrl_q.run),
        .pre_en (ctrl_q.pre_en),
        .ratio  (ctrl_q.ratio),
        .tick   (tick)
    );

    pet_count_core u_core (
        .clk       (clk),
        .rst       (core_rst),
        .tick      (tick),
        .autold    (ctrl_q.autold),
        .cmp_en    (ctrl_q.cmp_en),
        .load_val  (load_q),
        .match_val (match_q),
        .cnt_wr    (land_v[IX_COUNT]),
        .cnt_wdata (land_d[IX_COUNT]),
        .trig_wr   (land_v[IX_TRIG]),
        .count     (count),
        .ovf_evt   (ovf_evt),
        .mat_evt   (mat_evt),
        .stop_req  (stop_req)
    );

    pet_pin_gen u_pin (
        .clk     (clk),
        .rst     (core_rst),
        .ovf_evt (ovf_evt),
        .mat_evt (mat_evt),
        .trig    (ctrl_q.trig),
        .dflt    (ctrl_q.dflt),
        .toggle  (ctrl_q.toggle),
        .pin     (pwm_out)
    );

    assign irq = |(stat_q & ien_q);

    always_comb begin
        case (bus_addr)
            REG_CTRL:  bus_rdata = ctrl_q;
            REG_COUNT: bus_rdata = count;
            REG_LOAD:  bus_rdata = load_q;
            REG_MATCH: bus_rdata = match_q;
            REG_STAT:  bus_rdata = {{(DATA_W-STAT_W){1'b0}}, stat_q};
            REG_IEN:   bus_rdata = {{(DATA_W-STAT_W){1'b0}}, ien_q};
            REG_WPEND: bus_rdata = {{(DATA_W-NPOST){1'b0}}, wpend};
            REG_SYSST: bus_rdata = {{(DATA_W-1){1'b0}}, sys_done};
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pwm_event_timer_chk.sv
module pwm_event_timer_chk import pet_pkg::*; (
    input logic              clk,
    input logic              rst,
    input logic              core_rst,
    input logic              run,
    input logic              pre_en,
    input logic              autold,
    input logic              cnt_land,
    input logic              trig_land,
    input logic              ovf_evt,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W-1:0] load,
    input logic [STAT_W-1:0] ien,
    input logic              irq,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              busy,
    input logic [NPOST-1:0]  wpend,
    input logic              sys_done
);
    p_hold_r2: assert property (@(posedge clk) disable iff (core_rst)
        (!run && !cnt_land && !trig_land) |=> $stable(count));

    p_step_r2: assert property (@(posedge clk) disable iff (core_rst)
        (run && !pre_en && !cnt_land && !trig_land && count != '1)
        |=> count == DATA_W'($past(count) + 1'b1));

    p_reload_r4: assert property (@(posedge clk) disable iff (core_rst)
        (ovf_evt && autold) |=> count == $past(load));

    p_pend_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !busy && bus_addr == REG_LOAD) |=> wpend[IX_LOAD]);

    p_masked_r8: assert property (@(posedge clk) disable iff (rst)
        (ien == '0) |-> !irq);

    p_busy_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !busy && bus_addr == REG_IFCTL && bus_wdata == IFC_RESET_KEY) |=> !sys_done);
endmodule

bind pwm_event_timer pwm_event_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .core_rst  (core_rst),
    .run       (ctrl_q.run),
    .pre_en    (ctrl_q.pre_en),
    .autold    (ctrl_q.autold),
    .cnt_land  (land_v[1]),
    .trig_land (land_v[4]),
    .ovf_evt   (ovf_evt),
    .count     (count),
    .load      (load_q),
    .ien       (ien_q),
    .irq       (irq),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .wpend     (wpend),
    .sys_done  (sys_done)
);

// File: tb/pwm_event_timer_test.sv
module pwm_event_timer_test;
    localparam logic [3:0] A_CTRL = 4'd0, A_COUNT = 4'd1, A_LOAD = 4'd2, A_MATCH = 4'd3,
                           A_TRIG = 4'd4, A_STAT = 4'd5, A_IEN = 4'd6, A_WPEND = 4'd7,
                           A_IFCTL = 4'd8, A_SYSST = 4'd9;

    // pre_en, ratio, running cycles, expected ticks
    localparam int VEC [5][4] = '{
        '{0, 0, 10, 10},
        '{1, 0, 10, 5},
        '{1, 1, 10, 2},
        '{1, 2, 19, 2},
        '{1, 7, 600, 2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        pin;
    int          total = 0;
    int          bad = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    pwm_event_timer uut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq),
        .pwm_out   (pin)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog got=%h exp=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] c1;
        step(3);
        rst = 1'b0;
        // R1 reset state
        rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
        rd(A_COUNT, v); chk("R1 count", v, 0);
        rd(A_LOAD, v);  chk("R1 load", v, 0);
        rd(A_STAT, v);  chk("R1 status", v, 0);
        rd(A_WPEND, v); chk("R1 wpend", v, 0);
        rd(A_SYSST, v); chk("R1 sysstat", v, 1);
        chk("R1 pin", {31'd0, pin}, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 / R3 prescale table
        for (int i = 0; i < 5; i++) begin
            wr(A_CTRL, 0);
            wr(A_COUNT, 0);
            step(3);
            wr(A_CTRL, 32'(1 + VEC[i][0] * 32 + VEC[i][1] * 4));
            step(2 + VEC[i][2]);
            rd(A_COUNT, v);
            chk(VEC[i][0] == 0 ? "R2 tick per clock" : "R3 prescaled ticks", v, 32'(VEC[i][3]));
        end

        // R2 hold while stopped
        wr(A_CTRL, 1);
        step(5);
        wr(A_CTRL, 0);
        step(2);
        rd(A_COUNT, c1);
        step(6);
        rd(A_COUNT, v);
        chk("R2 hold when stopped", v, c1);

        // R12 preset
        wr(A_COUNT, 32'h1234);
        step(2);
        rd(A_COUNT, v); chk("R12 preset", v, 32'h1234);

        // R9 posted timing
        wr(A_LOAD, 32'h11);
        rd(A_WPEND, v); chk("R9 pending first cycle", v, 32'h4);
        rd(A_LOAD, v);  chk("R9 not landed", v, 0);
        step(1);
        rd(A_WPEND, v); chk("R9 pending second cycle", v, 32'h4);
        step(1);
        rd(A_WPEND, v); chk("R9 pending clear", v, 0);
        rd(A_LOAD, v);  chk("R9 landed", v, 32'h11);
        wr(A_LOAD, 32'h22);
        wr(A_LOAD, 32'h33);
        step(1);
        rd(A_LOAD, v);  chk("R9 first of pair", v, 32'h22);
        rd(A_WPEND, v); chk("R9 second in flight", v, 32'h4);
        step(1);
        rd(A_LOAD, v);  chk("R9 second of pair", v, 32'h33);
        rd(A_WPEND, v); chk("R9 pair drained", v, 0);

        // R6 trigger
        wr(A_COUNT, 5);
        step(2);
        rd(A_COUNT, v); chk("R12 preset small", v, 5);
        wr(A_TRIG, 32'hDEAD);
        step(1);
        rd(A_COUNT, v); chk("R6 before landing", v, 5);
        step(1);
        rd(A_COUNT, v); chk("R6 trigger copies load", v, 32'h33);

        // R4 auto-reload overflow
        wr(A_LOAD, 32'h100);
        wr(A_COUNT, 32'hFFFF_FFFE);
        wr(A_STAT, 3);
        step(2);
        wr(A_CTRL, 3);
        step(3);
        rd(A_COUNT, v); chk("R4 at max", v, 32'hFFFF_FFFF);
        step(1);
        rd(A_COUNT, v); chk("R4 reloaded", v, 32'h100);
        rd(A_STAT, v);  chk("R4 overflow flag", v, 1);
        chk("R8 masked irq", {31'd0, irq}, 0);
        step(1);
        rd(A_COUNT, v); chk("R4 keeps running", v, 32'h101);
        rd(A_CTRL, v);  chk("R4 run kept", v, 3);

        // R8 enable and write-one-to-clear
        wr(A_IEN, 1);
        chk("R8 irq enabled", {31'd0, irq}, 1);
        wr(A_STAT, 2);
        chk("R8 other bit write", {31'd0, irq}, 1);
        rd(A_STAT, v);  chk("R8 flag kept", v, 1);
        wr(A_STAT, 1);
        chk("R8 irq cleared", {31'd0, irq}, 0);
        rd(A_STAT, v);  chk("R8 flag cleared", v, 0);
        wr(A_CTRL, 0);
        step(2);

        // R5 one-shot overflow
        wr(A_COUNT, 32'hFFFF_FFFE);
        step(2);
        wr(A_CTRL, 1);
        step(4);
        rd(A_COUNT, v); chk("R5 wraps to zero", v, 0);
        rd(A_CTRL, v);  chk("R5 run cleared", v, 0);
        rd(A_STAT, v);  chk("R5 overflow flag", v, 1);
        chk("R8 irq from overflow", {31'd0, irq}, 1);
        step(3);
        rd(A_COUNT, v); chk("R5 stays stopped", v, 0);
        wr(A_STAT, 3);
        wr(A_IEN, 0);

        // R7 compare
        wr(A_COUNT, 0);
        wr(A_MATCH, 7);
        step(2);
        wr(A_CTRL, 32'h41);
        step(8);
        rd(A_COUNT, v); chk("R7 before match count", v, 6);
        rd(A_STAT, v);  chk("R7 no flag yet", v, 0);
        step(1);
        rd(A_STAT, v);  chk("R7 match flag", v, 2);
        rd(A_COUNT, v); chk("R7 at match", v, 7);
        wr(A_CTRL, 0);
        wr(A_STAT, 3);
        wr(A_COUNT, 0);
        step(2);
        wr(A_CTRL, 1);
        step(12);
        rd(A_COUNT, v); chk("R7 passes match disabled", v, 10);
        rd(A_STAT, v);  chk("R7 compare disabled", v, 0);
        wr(A_CTRL, 0);
        step(2);

        // R10 toggle on overflow
        wr(A_COUNT, 32'hFFFF_FFFD);
        wr(A_LOAD, 32'hFFFF_FFFD);
        step(2);
        wr(A_CTRL, 32'h503);
        step(4);
        chk("R10 toggle idle", {31'd0, pin}, 0);
        step(1);
        chk("R10 toggle first", {31'd0, pin}, 1);
        step(3);
        chk("R10 toggle second", {31'd0, pin}, 0);
        wr(A_CTRL, 0);
        step(3);
        chk("R10 no trigger mode", {31'd0, pin}, 0);

        // R10 pulse mode, idle high, overflow and match
        wr(A_COUNT, 32'hFFFF_FFFD);
        wr(A_MATCH, 32'hFFFF_FFFE);
        step(2);
        wr(A_CTRL, 32'h8C3);
        step(2);
        chk("R10 idle level high", {31'd0, pin}, 1);
        step(1);
        chk("R10 pulse on match", {31'd0, pin}, 0);
        step(1);
        chk("R10 pulse one clock", {31'd0, pin}, 1);
        step(1);
        chk("R10 pulse on overflow", {31'd0, pin}, 0);
        step(1);
        chk("R10 pulse on next match", {31'd0, pin}, 0);
        step(1);
        chk("R10 back to idle", {31'd0, pin}, 1);

        // R11 soft reset
        wr(A_IFCTL, 32'h6);
        rd(A_SYSST, v); chk("R11 busy at start", v, 0);
        step(3);
        rd(A_SYSST, v); chk("R11 busy last cycle", v, 0);
        step(1);
        rd(A_SYSST, v); chk("R11 done", v, 1);
        rd(A_CTRL, v);  chk("R11 ctrl cleared", v, 0);
        rd(A_COUNT, v); chk("R11 count cleared", v, 0);
        rd(A_MATCH, v); chk("R11 match cleared", v, 0);
        chk("R11 pin cleared", {31'd0, pin}, 0);
        wr(A_IFCTL, 32'h5);
        rd(A_SYSST, v); chk("R11 other value ignored", v, 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule